// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controller of a multicycle processor whose datapath shares one memory and one ALU across the steps of an instruction. It is a Moore state machine. On every clock it produces the full set of strobes and multiplexer selects the datapath needs for that step: PC load, conditional PC load, address source, memory read and write, instruction-register load, write-back source, destination-register select, register-file write, the two ALU operand selects, the ALU mode and the next-PC source.

Every instruction starts with a fetch step and a decode step. The decode step looks at the opcode from the instruction register and picks one of five instruction classes: register-register operations, loads, stores, conditional branches and jumps. Branches and jumps finish in three cycles, stores and register operations in four, and loads in five. An unknown opcode goes straight back to fetch. The current step is also brought out as a 4-bit phase code, so that a datapath or a bench can follow the sequence.

Top module: `mcc_control`

## Requirements
- R1: A synchronous active-high `rst` puts the sequencer in the fetch phase on the next rising edge, from any phase. The phase codes are: fetch 0, decode 1, address 2, load-read 3, load-writeback 4, store-write 5, reg-execute 6, reg-writeback 7, branch 8, jump 9.
- R2: In fetch, `pcLoad`, `memRd` and `instrLoad` are 1, `aluBSel`=01, and `aluASel`, `addrSel`, `memWr`, `rfWrite`, `aluMode` and `pcNextSel` are 0. This lets the ALU add 4 to the PC.
- R3: In decode, `aluASel`=0, `aluBSel`=11 and `aluMode`=00. The next phase is chosen from `opcode`: 000000 goes to reg-execute, 100011 and 101011 go to address, 000100 goes to branch, and 000010 goes to jump.
- R4: In address, `aluASel`=1, `aluBSel`=10 and `aluMode`=00. The next phase is load-read if decode saw 100011, and store-write otherwise.
- R5: In reg-execute, `aluASel`=1, `aluBSel`=00 and `aluMode`=10. The next phase is reg-writeback.
- R6: In branch, `aluASel`=1, `aluBSel`=00, `aluMode`=01, `pcNextSel`=01, `pcLoadIfZero`=1 and `pcLoad`=0. A branch takes three cycles.
- R7: In jump, `pcLoad`=1 and `pcNextSel`=10. A jump takes three cycles.
- R8: In load-read, `memRd`=1, `addrSel`=1 and `instrLoad`=0, and the next phase is load-writeback. In store-write, `memWr`=1 and `addrSel`=1, and a store takes four cycles.
- R9: In reg-writeback, `rfWrite`=1, `dstFromRd`=1 and `wbFromMem`=0.
- R10: In load-writeback, `rfWrite`=1, `dstFromRd`=0 and `wbFromMem`=1. Only a load reaches this phase.
- R11: In every phase, each output that the requirements above do not set is 0.
- R12: An opcode outside the five listed sends decode back to fetch. `opcode` has no effect in any phase other than decode.
- R13: Jump, branch, store-write, reg-writeback and load-writeback all go to fetch on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pcLoad | output | 1 | Unconditional PC write |
| pcLoadIfZero | output | 1 | PC write when the ALU result is zero |
| addrSel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| instrLoad | output | 1 | Instruction-register load |
| wbFromMem | output | 1 | Write-back data source: 1 = memory data |
| dstFromRd | output | 1 | Destination register: 1 = rd field, 0 = rt field |
| rfWrite | output | 1 | Register-file write strobe |
| aluASel | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| aluBSel | output | 2 | ALU operand B: 00 = reg B, 01 = 4, 10 = immediate, 11 = shifted immediate |
| aluMode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| pcNextSel | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| phase | output | 4 | Current phase code (see R1) |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode and the five standard class codes. With a 6-bit opcode, random draws cover the whole opcode space, so many undecoded opcodes reach decode and exercise the return to fetch. Random opcodes also change on every cycle, including the cycles after decode, which checks that the load/store choice is kept from decode. Resets are also fired at random in the middle of instructions.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int PHASE_W = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_FETCH   = 4'd0,
    PH_DECODE  = 4'd1,
    PH_ADDR    = 4'd2,
    PH_LDREAD  = 4'd3,
    PH_LDWB    = 4'd4,
    PH_STWRITE = 4'd5,
    PH_REXEC   = 4'd6,
    PH_RWB     = 4'd7,
    PH_BRANCH  = 4'd8,
    PH_JUMP    = 4'd9
  } phase_t;

  typedef struct packed {
    logic       pcLoad;
    logic       pcLoadIfZero;
    logic       addrSel;
    logic       memRd;
    logic       memWr;
    logic       instrLoad;
    logic       wbFromMem;
    logic       dstFromRd;
    logic       rfWrite;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic [1:0] aluMode;
    logic [1:0] pcNextSel;
  } strobes_t;
endpackage

// File: rtl/mcc_sequencer.sv
module mcc_sequencer
  import mcc_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_REG    = 6'b000000,
  parameter logic [OPW-1:0] OP_LOAD   = 6'b100011,
  parameter logic [OPW-1:0] OP_STORE  = 6'b101011,
  parameter logic [OPW-1:0] OP_BRANCH = 6'b000100,
  parameter logic [OPW-1:0] OP_JUMP   = 6'b000010
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output phase_t         curPhase
);
  phase_t nextPhase;
  logic   loadPending;
  logic   nextLoadPending;
  logic   isMemOp;

  assign isMemOp = (opcode == OP_LOAD) || (opcode == OP_STORE);

  always_comb begin
    nextPhase       = PH_FETCH;
    nextLoadPending = loadPending;
    case (curPhase)
      PH_FETCH:  nextPhase = PH_DECODE;
      PH_DECODE: begin
        nextLoadPending = (opcode == OP_LOAD);
        if (opcode == OP_REG)         nextPhase = PH_REXEC;
        else if (isMemOp)             nextPhase = PH_ADDR;
        else if (opcode == OP_BRANCH) nextPhase = PH_BRANCH;
        else if (opcode == OP_JUMP)   nextPhase = PH_JUMP;
        else                          nextPhase = PH_FETCH;
      end
      PH_ADDR:   nextPhase = loadPending ? PH_LDREAD : PH_STWRITE;
      PH_LDREAD: nextPhase = PH_LDWB;
      PH_REXEC:  nextPhase = PH_RWB;
      default:   nextPhase = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curPhase    <= PH_FETCH;
      loadPending <= 1'b0;
    end else begin
      curPhase    <= nextPhase;
      loadPending <= nextLoadPending;
    end
  end

  // R1: reset wins from any phase
  a_r1_reset_fetch: assert property (@(posedge clk) rst |=> curPhase == PH_FETCH);

  a_r3_load_dispatch: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_DECODE && opcode == OP_LOAD) |=> curPhase == PH_ADDR);

  a_r13_completion_returns: assert property (@(posedge clk) disable iff (rst)
    (curPhase == PH_JUMP || curPhase == PH_BRANCH || curPhase == PH_STWRITE ||
     curPhase == PH_RWB || curPhase == PH_LDWB) |=> curPhase == PH_FETCH);

  a_r10_wb_after_read: assert property (@(posedge clk) disable iff (rst)
    curPhase == PH_LDREAD |=> curPhase == PH_LDWB);

  a_r5_exec_then_wb: assert property (@(posedge clk) disable iff (rst)
    curPhase == PH_REXEC |=> curPhase == PH_RWB);
endmodule

// File: rtl/mcc_strobes.sv
module mcc_strobes
  import mcc_pkg::*;
(
  input  phase_t   curPhase,
  output strobes_t ctl
);
  always_comb begin
    ctl = '0;
    case (curPhase)
      PH_FETCH: begin
        ctl.pcLoad    = 1'b1;
        ctl.memRd     = 1'b1;
        ctl.instrLoad = 1'b1;
        ctl.aluBSel   = 2'b01;
      end
      PH_DECODE:  ctl.aluBSel = 2'b11;
      PH_ADDR: begin
        ctl.aluASel = 1'b1;
        ctl.aluBSel = 2'b10;
      end
      PH_LDREAD: begin
        ctl.memRd   = 1'b1;
        ctl.addrSel = 1'b1;
      end
      PH_LDWB: begin
        ctl.rfWrite   = 1'b1;
        ctl.wbFromMem = 1'b1;
      end
      PH_STWRITE: begin
        ctl.memWr   = 1'b1;
        ctl.addrSel = 1'b1;
      end
      PH_REXEC: begin
        ctl.aluASel = 1'b1;
        ctl.aluMode = 2'b10;
      end
      PH_RWB: begin
        ctl.rfWrite   = 1'b1;
        ctl.dstFromRd = 1'b1;
      end
      PH_BRANCH: begin
        ctl.aluASel      = 1'b1;
        ctl.aluMode      = 2'b01;
        ctl.pcNextSel    = 2'b01;
        ctl.pcLoadIfZero = 1'b1;
      end
      PH_JUMP: begin
        ctl.pcLoad    = 1'b1;
        ctl.pcNextSel = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

  // R11: memory strobes never overlap, and the PC write kinds never overlap
  always_comb begin
    a_r11_mem_exclusive: assert (!(ctl.memRd && ctl.memWr));
    a_r6_pc_write_exclusive: assert (!(ctl.pcLoad && ctl.pcLoadIfZero));
  end
endmodule

// File: rtl/mcc_control.sv
module mcc_control
  import mcc_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  output logic           pcLoad,
  output logic           pcLoadIfZero,
  output logic           addrSel,
  output logic           memRd,
  output logic           memWr,
  output logic           instrLoad,
  output logic           wbFromMem,
  output logic           dstFromRd,
  output logic           rfWrite,
  output logic           aluASel,
  output logic [1:0]     aluBSel,
  output logic [1:0]     aluMode,
  output logic [1:0]     pcNextSel,
  output logic [3:0]     phase
);
  phase_t   curPhase;
  strobes_t ctl;

  mcc_sequencer #(.OPW(OPW)) seqInst (
    .clk(clk), .rst(rst), .opcode(opcode), .curPhase(curPhase)
  );

  mcc_strobes strobeInst (.curPhase(curPhase), .ctl(ctl));

  assign phase        = curPhase;
  assign pcLoad       = ctl.pcLoad;
  assign pcLoadIfZero = ctl.pcLoadIfZero;
  assign addrSel      = ctl.addrSel;
  assign memRd        = ctl.memRd;
  assign memWr        = ctl.memWr;
  assign instrLoad    = ctl.instrLoad;
  assign wbFromMem    = ctl.wbFromMem;
  assign dstFromRd    = ctl.dstFromRd;
  assign rfWrite      = ctl.rfWrite;
  assign aluASel      = ctl.aluASel;
  assign aluBSel      = ctl.aluBSel;
  assign aluMode      = ctl.aluMode;
  assign pcNextSel    = ctl.pcNextSel;
endmodule

// File: tb/mcc_control_test.sv
`timescale 1ns/1ps
module mcc_control_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic pcLoad, pcLoadIfZero, addrSel, memRd, memWr, instrLoad;
  logic wbFromMem, dstFromRd, rfWrite, aluASel;
  logic [1:0] aluBSel, aluMode, pcNextSel;
  logic [3:0] phase;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcc_control uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pcLoad(pcLoad), .pcLoadIfZero(pcLoadIfZero), .addrSel(addrSel),
    .memRd(memRd), .memWr(memWr), .instrLoad(instrLoad),
    .wbFromMem(wbFromMem), .dstFromRd(dstFromRd), .rfWrite(rfWrite),
    .aluASel(aluASel), .aluBSel(aluBSel), .aluMode(aluMode),
    .pcNextSel(pcNextSel), .phase(phase)
  );

  localparam logic [5:0] OPC_REG = 6'b000000, OPC_LD = 6'b100011,
    OPC_ST = 6'b101011, OPC_BEQ = 6'b000100, OPC_J = 6'b000010;

  // order: pcLoad pcLoadIfZero addrSel memRd memWr instrLoad wbFromMem
  //        dstFromRd rfWrite aluASel aluBSel aluMode pcNextSel
  function automatic logic [15:0] expVec(input logic [3:0] ph);
    case (ph)
      4'd0: return 16'b1_0_0_1_0_1_0_0_0_0_01_00_00;
      4'd1: return 16'b0_0_0_0_0_0_0_0_0_0_11_00_00;
      4'd2: return 16'b0_0_0_0_0_0_0_0_0_1_10_00_00;
      4'd3: return 16'b0_0_1_1_0_0_0_0_0_0_00_00_00;
      4'd4: return 16'b0_0_0_0_0_0_1_0_1_0_00_00_00;
      4'd5: return 16'b0_0_1_0_1_0_0_0_0_0_00_00_00;
      4'd6: return 16'b0_0_0_0_0_0_0_0_0_1_00_10_00;
      4'd7: return 16'b0_0_0_0_0_0_0_1_1_0_00_00_00;
      4'd8: return 16'b0_1_0_0_0_0_0_0_0_1_00_01_01;
      4'd9: return 16'b1_0_0_0_0_0_0_0_0_0_00_00_10;
      default: return 16'hxxxx;
    endcase
  endfunction

  function automatic string vecTag(input logic [3:0] ph);
    case (ph)
      4'd0: return "R2/R11";
      4'd1: return "R3/R11";
      4'd2: return "R4/R11";
      4'd3, 4'd5: return "R8/R11";
      4'd4: return "R10/R11";
      4'd6: return "R5/R11";
      4'd7: return "R9/R11";
      4'd8: return "R6/R11";
      default: return "R7/R11";
    endcase
  endfunction

  logic [3:0] expPhase;
  logic benchLoad = 1'b0;
  string phTag = "R1";

  function automatic logic [3:0] nextOf(input logic [3:0] ph, input logic [5:0] op,
                                        input logic ld);
    case (ph)
      4'd0: return 4'd1;
      4'd1: begin
        if (op == OPC_REG) return 4'd6;
        if (op == OPC_LD || op == OPC_ST) return 4'd2;
        if (op == OPC_BEQ) return 4'd8;
        if (op == OPC_J) return 4'd9;
        return 4'd0;
      end
      4'd2: return ld ? 4'd3 : 4'd5;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  task automatic checkNow();
    logic [15:0] got;
    got = {pcLoad, pcLoadIfZero, addrSel, memRd, memWr, instrLoad, wbFromMem,
           dstFromRd, rfWrite, aluASel, aluBSel, aluMode, pcNextSel};
    checks++;
    if (phase !== expPhase) begin
      errors++;
      $display("FAIL %s phase: actual=%0d expected=%0d", phTag, phase, expPhase);
    end
    checks++;
    if (got !== expVec(expPhase)) begin
      errors++;
      $display("FAIL %s strobes in phase %0d: actual=%b expected=%b",
               vecTag(expPhase), expPhase, got, expVec(expPhase));
    end
  endtask

  // drive one cycle's inputs, then advance the model
  task automatic stepCycle(input logic [5:0] op, input logic r);
    opcode = op;
    rst    = r;
    if (r) phTag = "R1";
    else if (expPhase == 4'd1) begin
      if (op == OPC_REG || op == OPC_LD || op == OPC_ST || op == OPC_BEQ || op == OPC_J)
        phTag = "R3";
      else phTag = "R12";
    end
    else if (expPhase == 4'd2) phTag = "R8/R12";
    else if (expPhase == 4'd4 || expPhase == 4'd5 || expPhase == 4'd7 ||
             expPhase == 4'd8 || expPhase == 4'd9) phTag = "R13";
    else phTag = "R3/R5";
    if (r) expPhase = 4'd0;
    else begin
      if (expPhase == 4'd1) benchLoad = (op == OPC_LD);
      expPhase = nextOf(expPhase, op, benchLoad);
    end
    @(negedge clk);
    checkNow();
  endtask

  function automatic logic [5:0] pickOp();
    int sel;
    sel = int'($urandom_range(0, 7));
    case (sel)
      0: return OPC_REG;
      1: return OPC_LD;
      2: return OPC_ST;
      3: return OPC_BEQ;
      4: return OPC_J;
      default: return 6'($urandom_range(0, 63));
    endcase
  endfunction

  task automatic runInstr(input logic [5:0] op);
    // fetch cycle with noise opcode, then decode with op, then noise until fetch
    stepCycle(~op, 1'b0);
    stepCycle(op, 1'b0);
    for (int k = 0; k < 6 && expPhase != 4'd0; k++) stepCycle(6'($urandom_range(0, 63)), 1'b0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(posedge clk);
    @(negedge clk);
    expPhase = 4'd0;
    phTag = "R1";
    checkNow(); // reset state
    stepCycle(OPC_LD, 1'b0);
    expPhase = expPhase; // now in decode
    // directed: each class once from fetch (R10 load, R8 store, R6, R7, R5/R9)
    while (expPhase != 4'd0) stepCycle(6'd0, 1'b0);
    runInstr(OPC_LD);
    runInstr(OPC_ST);
    runInstr(OPC_BEQ);
    runInstr(OPC_J);
    runInstr(OPC_REG);
    runInstr(6'b111111); // R12 undecoded opcode
    // R1: reset in the middle of a load
    stepCycle(6'd5, 1'b0);
    stepCycle(OPC_LD, 1'b0);
    stepCycle(6'd0, 1'b0);
    stepCycle(6'd0, 1'b1);
    stepCycle(OPC_LD, 1'b0);
    // random traffic
    for (int i = 0; i < 3000; i++)
      stepCycle(pickOp(), ($urandom_range(0, 99) == 0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule